// File: doc/BRIEF.md
# Adaptive Step-Size Coefficient Updater

This block applies the learning rule that adapts the two cross-feedback unmixing filters of a two-channel source separator. Each update request names one coefficient: a filter select and a tap index. It also carries two separated output samples: the "driving" sample u_i and the "partner" sample u_j. The block bends u_i through a saturating, piecewise-linear logistic curve. It scales the result by the current learning step to get a gain K. It then adds K·u_i·u_j to the addressed coefficient in an external dual-port coefficient memory, through a read-modify-write pipeline.

The learning step starts at a fixed value. It falls by a constant on each completed iteration pass and stops at zero, so no exponential, lookup table or iterative rotation unit is needed. Back-to-back requests may name the same coefficient. The pipeline forwards its own last write so that no update is lost.

Top module: `coef_updater`

## Requirements
- R1: During reset and in the first cycle after it, neither memory strobe (`mem_rd_en`, `mem_wr_en`) is asserted. The step value after reset is the initial value.
- R2: The step λ is an unsigned count of 2^-24 units. It starts at 10050, which is 201 × 50. Each `iter_done` pulse lowers it by 201.
- R3: After 50 pulses λ is zero and stays zero under further pulses. Every update then rewrites the coefficient with its unchanged value.
- R4: With u_i in signed Q4.12, the score g = 1 − 2y is computed from y = 0.5 + u/8 clipped to [0,1]. In integers, g = clamp(−(u_i >>> 2), −4096, +4096) in Q.12. It is pinned at ±1 whenever |u_i| ≥ 4.0.
- R5: K = (λ·g) >>> 12. Each coefficient is signed Q4.20 in 24 bits, and the written value is old + ((K·u_i·u_j) >>> 28). All shifts are arithmetic.
- R6: The coefficient address is {`upd_sel`, `upd_tap`}. Select 0 holds the first cross filter and select 1 the second. Valid taps are 0 to 160.
- R7: A request with a valid tap drives `mem_rd_en` and `mem_rd_addr` combinationally in its own cycle. The memory returns data on the next edge. The matching write (`mem_wr_en`, address, data) appears in the following cycle.
- R8: When a request names the address written at the same edge its read is taken, the block uses its own written value and not the stale memory data. Consecutive updates to one coefficient therefore accumulate.
- R9: The written value saturates at +8388607 and −8388608.
- R10: A request with tap ≥ 161 is ignored: no read strobe in its cycle and no write in the next.
- R11: An update presented in the same cycle as `iter_done` uses λ from before the decrement. An update one cycle later uses the lowered λ.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| iter_done | input | 1 | Pulse marking the end of one iteration pass |
| upd_valid | input | 1 | Update request valid |
| upd_sel | input | 1 | Cross filter select |
| upd_tap | input | 8 | Tap index, offset so the centre tap is 80 |
| upd_ui | input | 16 | Driving output sample, signed Q4.12 |
| upd_uj | input | 16 | Partner output sample, signed Q4.12 |
| mem_rd_en | output | 1 | Coefficient memory read strobe |
| mem_rd_addr | output | 9 | Coefficient memory read address |
| mem_rd_data | input | 24 | Read data, one cycle after the strobe |
| mem_wr_en | output | 1 | Coefficient memory write strobe |
| mem_wr_addr | output | 9 | Coefficient memory write address |
| mem_wr_data | output | 24 | Updated coefficient, signed Q4.20 |

## Verification
Two pairs of functions can land in the same cycle. The first is a step decrement together with an update: the bench drives `iter_done` alongside a request and then repeats the request one cycle later. Each delta is judged against a model λ that changes only after the request that shares its cycle. The second is a write together with a read of the same coefficient: long runs of back-to-back requests to one tap are issued, and the bench memory model returns stale data in that case. The running sum, which also drives the value into saturation, only matches the model if forwarding works.

// File: rtl/bssu_pkg.sv
// Package: default sizes shared by the coefficient updater and its bench.
// Assumes: the top module takes these as parameter defaults.
package bssu_pkg;
    localparam int DEF_TAPS      = 161;  // coefficients per cross filter
    localparam int DEF_U_W       = 16;   // sample width
    localparam int DEF_U_FRAC    = 12;   // sample fraction bits
    localparam int DEF_LAM_W     = 24;   // step register width (all fraction)
    localparam int DEF_COEF_W    = 24;   // coefficient width
    localparam int DEF_COEF_FRAC = 20;   // coefficient fraction bits
    localparam int DEF_LAM_STEP  = 201;  // step decrement per pass
    localparam int DEF_MAX_ITER  = 50;   // passes until the step reaches zero
endpackage

// File: rtl/step_sched.sv
// step_sched: holds the learning step as a pure-fraction register.
// It loads STEP*MAX_ITER on reset, drops by STEP on each iter_done
// pulse and sticks at zero.
// Assumes: iter_done is a single-cycle pulse per completed pass.
module step_sched #(
    parameter int LAM_W    = 24,
    parameter int LAM_STEP = 201,
    parameter int MAX_ITER = 50
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             iter_done,
    output logic [LAM_W-1:0] lam
);
    localparam logic [LAM_W-1:0] STEP_L = LAM_W'(LAM_STEP);
    localparam logic [LAM_W-1:0] INIT_L = LAM_W'(LAM_STEP * MAX_ITER);

    // Linear ramp: reload on reset, subtract per pass, clamp at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lam <= INIT_L;
        end else if (iter_done) begin
            lam <= (lam > STEP_L) ? (lam - STEP_L) : '0;
        end
    end

    // R2: a pass with room to spare lowers the step by exactly one decrement
    a_r2_step_down: assert property (@(posedge clk) disable iff (!rst_n)
        (iter_done && lam >= STEP_L) |=> (lam == $past(lam) - STEP_L));
    // R3: once zero, the step never rises again until reset
    a_r3_zero_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        (lam == '0) |=> (lam == '0));
    // R3: a pass that would underflow lands on zero
    a_r3_clamp: assert property (@(posedge clk) disable iff (!rst_n)
        (iter_done && lam < STEP_L) |=> (lam == '0));
endmodule

// File: rtl/score_nl.sv
// score_nl: combinational score g = 1 - 2*y, with y a piecewise-linear
// logistic (0.5 + u/8 clipped to [0,1]). So g = -u/4 clipped to +/-1.
// Assumes: u has U_FRAC fraction bits and g is returned with the same
// fraction count.
module score_nl #(
    parameter int U_W    = 16,
    parameter int U_FRAC = 12,
    localparam int G_W   = U_FRAC + 2
) (
    input  logic signed [U_W-1:0] u,
    output logic signed [G_W-1:0] g
);
    localparam logic signed [U_W:0] ONE_X = (U_W+1)'(2 ** U_FRAC);
    localparam logic signed [G_W-1:0] ONE_G = G_W'(2 ** U_FRAC);

    logic signed [U_W:0] neg_q;

    // Slope stage: negate a quarter of the sample in one extra bit.
    always_comb begin
        neg_q = -($signed({u[U_W-1], u}) >>> 2);
    end

    generate
        if (U_W - U_FRAC >= 4) begin : g_clip
            // Clip stage: samples beyond +/-4.0 pin the score at -/+1.
            always_comb begin
                if (neg_q > ONE_X)       g = ONE_G;
                else if (neg_q < -ONE_X) g = -ONE_G;
                else                     g = neg_q[G_W-1:0];
            end
        end else begin : g_noclip
            // Sample range never reaches +/-4.0, so no clip is needed.
            always_comb begin
                g = neg_q[G_W-1:0];
            end
        end
    endgenerate

    // R4: the score stays within +/-1 and never shares the sign of u
    always_comb begin
        a_r4_range: assert (g <= ONE_G && g >= -ONE_G);
        a_r4_sign:  assert (!(u > 0 && g > 0) && !(u < 0 && g < 0));
    end
endmodule

// File: rtl/coef_rmw.sv
// coef_rmw: two-stage read-modify-write of one coefficient per cycle.
// Stage 0 (in the caller) issues the read. Stage 1 takes the memory data
// (or the value written at the edge where the read happened), adds the
// scaled product with saturation, and drives the write.
// Assumes: the memory has a registered read port returning data one cycle
// after the address, and a read that meets a write at the same edge
// returns the old value.
module coef_rmw #(
    parameter int ADDR_W = 9,
    parameter int COEF_W = 24,
    parameter int KW     = 26,
    parameter int PW     = 32,
    parameter int SH     = 28
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic signed [KW-1:0]     req_k,
    input  logic signed [PW-1:0]     req_p,
    input  logic [COEF_W-1:0]        rd_data,
    output logic                     wr_en,
    output logic [ADDR_W-1:0]        wr_addr,
    output logic [COEF_W-1:0]        wr_data
);
    localparam int PROD_W = KW + PW;
    localparam logic signed [PROD_W-1:0] C_MAX =
        {{(PROD_W-COEF_W+1){1'b0}}, {(COEF_W-1){1'b1}}};
    localparam logic signed [PROD_W-1:0] C_MIN =
        {{(PROD_W-COEF_W+1){1'b1}}, {(COEF_W-1){1'b0}}};

    logic                     s1_v;
    logic [ADDR_W-1:0]        s1_a;
    logic signed [KW-1:0]     s1_k;
    logic signed [PW-1:0]     s1_p;
    logic                     fw_v;
    logic [ADDR_W-1:0]        fw_a;
    logic [COEF_W-1:0]        fw_d;
    logic [COEF_W-1:0]        base;
    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W-1:0] sum;

    // Stage 1 registers: request captured alongside the memory read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_v <= 1'b0;
            s1_a <= '0;
            s1_k <= '0;
            s1_p <= '0;
        end else begin
            s1_v <= req_valid;
            s1_a <= req_addr;
            s1_k <= req_k;
            s1_p <= req_p;
        end
    end

    // Forward register: the write that coincided with the next read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fw_v <= 1'b0;
            fw_a <= '0;
            fw_d <= '0;
        end else begin
            fw_v <= s1_v;
            fw_a <= s1_a;
            fw_d <= wr_data;
        end
    end

    // Update datapath: choose the fresh base, add the shifted product, saturate.
    always_comb begin
        base = (fw_v && fw_a == s1_a) ? fw_d : rd_data;
        prod = $signed({{(PROD_W-KW){s1_k[KW-1]}}, s1_k})
             * $signed({{(PROD_W-PW){s1_p[PW-1]}}, s1_p});
        sum  = $signed({{(PROD_W-COEF_W){base[COEF_W-1]}}, base}) + (prod >>> SH);
        if (sum > C_MAX)      wr_data = C_MAX[COEF_W-1:0];
        else if (sum < C_MIN) wr_data = C_MIN[COEF_W-1:0];
        else                  wr_data = sum[COEF_W-1:0];
        wr_en   = s1_v;
        wr_addr = s1_a;
    end

    // R8: a forwarded base always comes from the write one cycle earlier
    a_r8_fwd_source: assert property (@(posedge clk) disable iff (!rst_n)
        fw_v |-> $past(wr_en));
endmodule

// File: rtl/coef_updater.sv
// coef_updater: adaptive-step learning update for the two cross filters.
// Stage 0 checks the tap, issues the coefficient read and forms
// K = lam*g and the sample product. coef_rmw finishes the accumulate
// one cycle later.
// Assumes: an external dual-port coefficient memory with registered read,
// addressed {select, tap}.
module coef_updater
    import bssu_pkg::*;
#(
    parameter int TAPS      = DEF_TAPS,
    parameter int U_W       = DEF_U_W,
    parameter int U_FRAC    = DEF_U_FRAC,
    parameter int LAM_W     = DEF_LAM_W,
    parameter int COEF_W    = DEF_COEF_W,
    parameter int COEF_FRAC = DEF_COEF_FRAC,
    parameter int LAM_STEP  = DEF_LAM_STEP,
    parameter int MAX_ITER  = DEF_MAX_ITER,
    localparam int TAP_W    = $clog2(TAPS),
    localparam int ADDR_W   = TAP_W + 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  iter_done,
    input  logic                  upd_valid,
    input  logic                  upd_sel,
    input  logic [TAP_W-1:0]      upd_tap,
    input  logic signed [U_W-1:0] upd_ui,
    input  logic signed [U_W-1:0] upd_uj,
    output logic                  mem_rd_en,
    output logic [ADDR_W-1:0]     mem_rd_addr,
    input  logic [COEF_W-1:0]     mem_rd_data,
    output logic                  mem_wr_en,
    output logic [ADDR_W-1:0]     mem_wr_addr,
    output logic [COEF_W-1:0]     mem_wr_data
);
    localparam int G_W   = U_FRAC + 2;
    localparam int KW    = LAM_W + 2;
    localparam int PW    = 2 * U_W;
    localparam int KP_W  = LAM_W + 1 + G_W;
    localparam int SH    = LAM_W + 2 * U_FRAC - COEF_FRAC;

    logic [LAM_W-1:0]        lam;
    logic signed [G_W-1:0]   g;
    logic signed [KP_W-1:0]  k_full;
    logic signed [KW-1:0]    k_val;
    logic signed [PW-1:0]    p_val;
    logic                    tap_ok;

    step_sched #(.LAM_W(LAM_W), .LAM_STEP(LAM_STEP), .MAX_ITER(MAX_ITER)) u_sched (
        .clk       (clk),
        .rst_n     (rst_n),
        .iter_done (iter_done),
        .lam       (lam)
    );

    score_nl #(.U_W(U_W), .U_FRAC(U_FRAC)) u_score (
        .u (upd_ui),
        .g (g)
    );

    // Stage 0: range check, read issue, gain and sample product.
    always_comb begin
        tap_ok      = (32'(upd_tap) < TAPS);
        mem_rd_en   = upd_valid && tap_ok;
        mem_rd_addr = {upd_sel, upd_tap};
        k_full      = $signed({{(KP_W-LAM_W){1'b0}}, lam})
                    * $signed({{(KP_W-G_W){g[G_W-1]}}, g});
        k_val       = KW'(k_full >>> U_FRAC);
        p_val       = $signed({{U_W{upd_ui[U_W-1]}}, upd_ui})
                    * $signed({{U_W{upd_uj[U_W-1]}}, upd_uj});
    end

    coef_rmw #(.ADDR_W(ADDR_W), .COEF_W(COEF_W), .KW(KW), .PW(PW), .SH(SH)) u_rmw (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (mem_rd_en),
        .req_addr  (mem_rd_addr),
        .req_k     (k_val),
        .req_p     (p_val),
        .rd_data   (mem_rd_data),
        .wr_en     (mem_wr_en),
        .wr_addr   (mem_wr_addr),
        .wr_data   (mem_wr_data)
    );

    // R7: every read is followed by a write in the next cycle
    a_r7_write_follows: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> mem_wr_en);
    // R10: no write without a read one cycle earlier
    a_r10_no_write_alone: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_rd_en |=> !mem_wr_en);
    // R6: the write goes to the address read one cycle earlier
    a_r6_same_addr: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> (mem_wr_addr == $past(mem_rd_addr)));
endmodule

// File: tb/coef_updater_tb_top.sv
`timescale 1ns/1ps
module coef_updater_tb_top;
    localparam int TAPS = 161;
    localparam int STEP = 201;
    localparam int LAM0 = 201 * 50;
    localparam int CMAX = 8388607;
    localparam int CMIN = -8388608;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        iter_done = 1'b0;
    logic        upd_valid = 1'b0;
    logic        upd_sel = 1'b0;
    logic [7:0]  upd_tap = '0;
    logic signed [15:0] upd_ui = '0;
    logic signed [15:0] upd_uj = '0;
    logic        mem_rd_en;
    logic [8:0]  mem_rd_addr;
    logic [23:0] mem_rd_data;
    logic        mem_wr_en;
    logic [8:0]  mem_wr_addr;
    logic [23:0] mem_wr_data;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    int          ref_mem [512];
    logic [23:0] mem     [512];
    int          lam_ref;
    bit          pend_v = 1'b0;
    int          pend_a;
    int          pend_d;
    string       pend_tag = "R1";

    always #10 clk = ~clk;

    coef_updater dut_i (
        .clk(clk), .rst_n(rst_n), .iter_done(iter_done),
        .upd_valid(upd_valid), .upd_sel(upd_sel), .upd_tap(upd_tap),
        .upd_ui(upd_ui), .upd_uj(upd_uj),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data)
    );

    function automatic int init_val(input int a);
        return ((a * 2749 + 91) % 4093 - 2046) * 997;
    endfunction

    // Coefficient memory model: registered read, read-before-write.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int a = 0; a < 512; a++) mem[a] <= 24'(init_val(a));
            mem_rd_data <= '0;
        end else begin
            if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr];
            if (mem_wr_en) mem[mem_wr_addr] <= mem_wr_data;
        end
    end

    function automatic int score(input int u);
        int t;
        t = -(u >>> 2);
        if (t > 4096)  t = 4096;
        if (t < -4096) t = -4096;
        return t;
    endfunction

    function automatic int sat24(input longint v);
        if (v > CMAX) return CMAX;
        if (v < CMIN) return CMIN;
        return int'(v);
    endfunction

    task automatic chk(input string tag, input string what, input longint act, input longint exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // One cycle: check last cycle's write, drive a new request, check its read.
    task automatic cyc(input bit v, input bit s, input int tp, input int ui, input int uj,
                       input bit dn, input string tag);
        bit ok;
        int a;
        longint kk, pp, d;
        chk(pend_tag, "wr_en", longint'(mem_wr_en), longint'(pend_v));
        if (pend_v && mem_wr_en) begin
            chk(pend_tag, "wr_addr", longint'(mem_wr_addr), longint'(pend_a));
            chk(pend_tag, "wr_data", longint'($signed(mem_wr_data)), longint'(pend_d));
        end
        upd_valid = v; upd_sel = s; upd_tap = tp[7:0];
        upd_ui = ui[15:0]; upd_uj = uj[15:0]; iter_done = dn;
        ok = v && (tp < TAPS);
        if (ok) begin
            a  = (s ? 256 : 0) + tp;
            kk = (longint'(lam_ref) * score(ui)) >>> 12;
            pp = longint'(ui) * longint'(uj);
            d  = (kk * pp) >>> 28;
            ref_mem[a] = sat24(longint'(ref_mem[a]) + d);
            pend_a = a;
            pend_d = ref_mem[a];
        end
        pend_v = ok;
        pend_tag = tag;
        if (dn) lam_ref = (lam_ref > STEP) ? lam_ref - STEP : 0;
        #1;
        chk(tag, "rd_en", longint'(mem_rd_en), longint'(ok));
        if (ok) chk(tag, "rd_addr", longint'(mem_rd_addr), longint'(pend_a));
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        for (int a = 0; a < 512; a++) ref_mem[a] = init_val(a);
        lam_ref = LAM0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk("R1", "rd_en in reset", longint'(mem_rd_en), 0);
        chk("R1", "wr_en in reset", longint'(mem_wr_en), 0);
        rst_n = 1'b1;
        @(posedge clk); @(negedge clk);
        chk("R1", "wr_en after reset", longint'(mem_wr_en), 0);
        // R1: first update uses the initial step
        cyc(1, 0, 30, -32768, -32768, 0, "R1");

        // R4: score across the linear range and both clip edges
        cyc(1, 0, 0,   -16384, 30000, 0, "R4");
        cyc(1, 0, 1,   -16383, 30000, 0, "R4");
        cyc(1, 0, 2,    16384, 30000, 0, "R4");
        cyc(1, 0, 3,    20000, -30000, 0, "R4");
        cyc(1, 0, 4,        0, 30000, 0, "R4");
        cyc(1, 0, 6,        1, 30000, 0, "R4");
        cyc(1, 0, 7,       -1, 30000, 0, "R4");
        cyc(1, 0, 8,     4095, -32768, 0, "R4");
        cyc(1, 0, 9,    -4097, 32767, 0, "R4");
        // R6: both filters, both end taps
        cyc(1, 1, 0,    -9000, 12000, 0, "R6");
        cyc(1, 0, 160,  -9000, 12000, 0, "R6");
        cyc(1, 1, 160,   7000, -7000, 0, "R6");
        cyc(1, 1, 80,   -3000, 25000, 0, "R6");
        // R5: mixed sign products
        cyc(1, 0, 40,  -12000, -20000, 0, "R5");
        cyc(1, 1, 41,   11000, -21000, 0, "R5");
        cyc(0, 0, 0, 0, 0, 0, "R7");
        // R8: back-to-back and gap-one hits on the same coefficient
        cyc(1, 0, 50, -15000, 20000, 0, "R8");
        cyc(1, 0, 50, -25000, 17000, 0, "R8");
        cyc(1, 0, 50,  14000, 19000, 0, "R8");
        cyc(1, 1, 50,  -5000, 5000, 0, "R8");
        cyc(1, 0, 50, -30000, -30000, 0, "R8");
        // R9: drive one coefficient to each rail and hold it there
        for (int i = 0; i < 220; i++) cyc(1, 0, 5, -32768, -32768, 0, "R9");
        for (int i = 0; i < 220; i++) cyc(1, 1, 160, -32768, 32767, 0, "R9");
        // R10: out-of-range taps are ignored
        cyc(1, 0, 161, -20000, 20000, 0, "R10");
        cyc(1, 1, 255, -20000, 20000, 0, "R10");
        cyc(0, 0, 0, 0, 0, 0, "R10");
        // R2: one decrement between two identical updates
        cyc(1, 0, 20, -32768, -32768, 0, "R2");
        cyc(0, 0, 0, 0, 0, 1, "R2");
        cyc(1, 0, 20, -32768, -32768, 0, "R2");
        // R11: update in the decrement cycle, then one cycle after
        cyc(1, 0, 21, -32768, -32768, 1, "R11");
        cyc(1, 0, 21, -32768, -32768, 0, "R11");
        cyc(1, 1, 22, -32768, 32767, 1, "R11");
        cyc(1, 1, 22, -32768, 32767, 0, "R11");
        // R5: random mix of requests, taps (some out of range) and passes
        for (int i = 0; i < 400; i++) begin
            int ui, uj, tp;
            bit v, s, dn;
            v  = ($urandom_range(0, 3) != 0);
            s  = $urandom_range(0, 1);
            tp = (i % 8 == 0) ? 5 + (i % 3) : $urandom_range(0, 170);
            ui = $urandom_range(0, 65535) - 32768;
            uj = $urandom_range(0, 65535) - 32768;
            dn = ($urandom_range(0, 24) == 0);
            cyc(v, s, tp, ui, uj, dn, "R5");
        end
        // R3: run the step into zero, keep pulsing, then update
        for (int i = 0; i < 60; i++) cyc(0, 0, 0, 0, 0, 1, "R3");
        for (int i = 0; i < 10; i++) cyc(1, i % 2, 10 + i, -32768, -32768, i % 3 == 0, "R3");
        cyc(0, 0, 0, 0, 0, 0, "R3");
        cyc(0, 0, 0, 0, 0, 0, "R3");
        done = 1'b1;
        summary();
        $finish;
    end
endmodule